// File: doc/BRIEF.md
# Synthetic Mesh Traffic Injector

This block is a per-node packet source used to load a two-dimensional mesh network-on-chip with synthetic traffic. It runs one injection decision per free output cycle. A 16-bit LFSR supplies a pseudo-random draw, which is reduced to the range 0 .. 10^PRECISION-1. A packet is offered only when this draw is below the configured rate. The packet's destination comes from the node's own ID and one of several classic permutation patterns, worked out on (x, y) mesh coordinates.

The mesh is square, with a radix of 2^RADIX_BITS, so the node count N is the square of the radix and node IDs are 2·RADIX_BITS bits wide. A node's x coordinate is the low half of its ID, which is ID mod radix. Its y coordinate is the high half, which is ID / radix. Two overrides narrow the traffic for directed tests. The first restricts injection to a single sender node. The second forces every packet to a single configured destination.

Each packet is offered on a valid/ready port and carries three fields:
- the destination ID;
- an address that holds the destination above the block offset;
- a request class.

While a packet waits at the port, it is held unchanged and no new draw is made.

Top module: `traffic_injector`

## Requirements
- R1: While rst_n is low (synchronous, active low), pktValid, pktDest, pktAddr and pktClass are all zero. At reset the LFSR loads SEED XOR nodeId, or 1 if that value is zero.
- R2: A cycle is free when pktValid is low or pktReady is high. In a free cycle the draw is the LFSR state mod 10^PRECISION, and a packet can be offered only if the draw is below injRate. With injRate 0 no packet is ever offered. With injRate 10^PRECISION a packet is offered after every free cycle.
- R3: Pattern code 1 (complement) sends to x' = radix-1-x, y' = radix-1-y, destination = y'·radix + x'.
- R4: Pattern code 2 (bit reverse) sends to the node ID with its log2(N) bits reversed, so bit i goes to bit log2(N)-1-i.
- R5: Pattern code 3 (shuffle) sends a source below N/2 to 2·source, and any other source to 2·source - N + 1.
- R6: Pattern code 4 (transpose) sends (x, y) to the node x·radix + y.
- R7: Pattern code 5 (neighbour) sends to ((x+1) mod radix, y). Pattern code 6 (tornado) sends to ((x + radix/2 - 1) mod radix, y).
- R8: Pattern code 0 (uniform) takes the destination from the top log2(N) bits of the LFSR state, so every node is reachable. Pattern code 7 never produces a packet.
- R9: The reqClass input is carried into pktClass. Code 0 is read, code 1 is instruction fetch, code 2 is write. Code 3 never produces a packet.
- R10: pktAddr equals pktDest shifted left by BLOCK_OFFSET, and its low BLOCK_OFFSET bits are zero.
- R11: When singleSenderEn is high, only a node whose nodeId equals senderId offers packets.
- R12: When singleDestEn is high, every packet loaded is addressed to destCfg, whatever the pattern.
- R13: While pktValid is high and pktReady is low, pktValid, pktDest, pktAddr and pktClass hold their values even if the configuration inputs change. The next packet is formed only after the handshake.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| nodeId | input | 2*RADIX_BITS | This node's ID |
| pattern | input | 3 | Traffic pattern code |
| reqClass | input | 2 | Request class code |
| injRate | input | clog2(10^PRECISION+1) | Injection rate, in units of 10^-PRECISION |
| singleSenderEn | input | 1 | Restrict injection to senderId |
| senderId | input | 2*RADIX_BITS | The only node allowed to send in single-sender mode |
| singleDestEn | input | 1 | Force every destination to destCfg |
| destCfg | input | 2*RADIX_BITS | Forced destination |
| pktValid | output | 1 | Packet offered |
| pktReady | input | 1 | Consumer accepts the packet |
| pktDest | output | 2*RADIX_BITS | Destination node ID |
| pktAddr | output | ADDR_W | Address with the destination above the block offset |
| pktClass | output | 2 | Request class |

## Verification
The bench builds the block with RADIX_BITS = 3, giving an 8x8 mesh of 64 nodes, along with PRECISION = 2 and BLOCK_OFFSET = 6. With radix 8 the tornado offset is 3 and differs from the neighbour shift. The 6-bit bit reversal is not symmetric, and shuffle has a real upper half. Every node is swept through all six deterministic patterns, and each result is compared with coordinate arithmetic done in the bench. With a range of 100, the rate extremes of 0 and 100 can be checked exactly, and a 50 % setting can be checked statistically. The bench also runs long uniform traffic to show that all 64 destinations are reached, and it covers stalls, invalid codes and both override modes.

// File: rtl/traffic_injector_pkg.sv
package traffic_injector_pkg;

  typedef enum logic [2:0] {
    PAT_UNIFORM    = 3'd0,
    PAT_COMPLEMENT = 3'd1,
    PAT_REVERSE    = 3'd2,
    PAT_SHUFFLE    = 3'd3,
    PAT_TRANSPOSE  = 3'd4,
    PAT_NEIGHBOR   = 3'd5,
    PAT_TORNADO    = 3'd6,
    PAT_NONE       = 3'd7
  } pattern_e;

  localparam logic [1:0] CLASS_READ  = 2'd0;
  localparam logic [1:0] CLASS_FETCH = 2'd1;
  localparam logic [1:0] CLASS_WRITE = 2'd2;
  localparam logic [1:0] CLASS_BAD   = 2'd3;

  // strobes from control to datapath
  typedef struct packed {
    logic draw;   // advance the random source
    logic load;   // capture a new packet
  } ctlStrobes_t;

endpackage

// File: rtl/traffic_injector_dp.sv
module traffic_injector_dp
  import traffic_injector_pkg::*;
#(
  parameter int          RADIX_BITS   = 2,
  parameter int          BLOCK_OFFSET = 6,
  parameter int          ADDR_W       = 32,
  parameter int          PRECISION    = 2,
  parameter logic [15:0] SEED         = 16'hACE1,
  localparam int NODE_W = 2 * RADIX_BITS,
  localparam int RANGE  = 10 ** PRECISION,
  localparam int RATE_W = $clog2(RANGE + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NODE_W-1:0] nodeId,
  input  pattern_e          pattern,
  input  logic [1:0]        reqClass,
  input  logic              singleDestEn,
  input  logic [NODE_W-1:0] destCfg,
  input  ctlStrobes_t       strobes,
  output logic [RATE_W-1:0] drawVal,
  output logic              patternOk,
  output logic [NODE_W-1:0] pktDest,
  output logic [ADDR_W-1:0] pktAddr,
  output logic [1:0]        pktClass
);

  localparam int NUM_NODES = 1 << NODE_W;
  localparam int RADIX     = 1 << RADIX_BITS;
  localparam logic [RADIX_BITS-1:0] TORN_OFS = RADIX_BITS'(RADIX / 2 - 1);
  localparam logic [15:0] LFSR_TAPS = 16'hB400;

  // random source
  logic [15:0] lfsr;
  logic [15:0] seedVal;
  logic [15:0] drawFull;

  assign seedVal = SEED ^ 16'(nodeId);

  always_ff @(posedge clk) begin
    if (!rst_n)
      lfsr <= (seedVal == 16'h0) ? 16'h1 : seedVal;
    else if (strobes.draw)
      lfsr <= {1'b0, lfsr[15:1]} ^ (lfsr[0] ? LFSR_TAPS : 16'h0);
  end

  assign drawFull = lfsr % 16'(RANGE);
  assign drawVal  = RATE_W'(drawFull);

  // pattern arithmetic
  logic [RADIX_BITS-1:0] srcX, srcY, neighX, tornX;
  logic [NODE_W-1:0]     revId, shufId, patDest, destNext;
  logic [NODE_W:0]       shufWide;

  assign srcX   = nodeId[RADIX_BITS-1:0];
  assign srcY   = nodeId[NODE_W-1:RADIX_BITS];
  assign neighX = srcX + RADIX_BITS'(1);
  assign tornX  = srcX + TORN_OFS;

  for (genvar g = 0; g < NODE_W; g++) begin : gRev
    assign revId[g] = nodeId[NODE_W-1-g];
  end

  assign shufWide = {nodeId, 1'b0} - (NODE_W+1)'(NUM_NODES - 1);
  assign shufId   = nodeId[NODE_W-1] ? shufWide[NODE_W-1:0]
                                     : {nodeId[NODE_W-2:0], 1'b0};

  always_comb begin
    patternOk = 1'b1;
    case (pattern)
      PAT_UNIFORM:    patDest = lfsr[15 -: NODE_W];
      PAT_COMPLEMENT: patDest = {~srcY, ~srcX};
      PAT_REVERSE:    patDest = revId;
      PAT_SHUFFLE:    patDest = shufId;
      PAT_TRANSPOSE:  patDest = {srcX, srcY};
      PAT_NEIGHBOR:   patDest = {srcY, neighX};
      PAT_TORNADO:    patDest = {srcY, tornX};
      default: begin
        patDest   = '0;
        patternOk = 1'b0;
      end
    endcase
  end

  assign destNext = singleDestEn ? destCfg : patDest;

  // packet registers
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pktDest  <= '0;
      pktAddr  <= '0;
      pktClass <= '0;
    end else if (strobes.load) begin
      pktDest  <= destNext;
      pktAddr  <= ADDR_W'(destNext) << BLOCK_OFFSET;
      pktClass <= reqClass;
    end
  end

endmodule

// File: rtl/traffic_injector_ctl.sv
module traffic_injector_ctl
  import traffic_injector_pkg::*;
#(
  parameter int NODE_W = 4,
  parameter int RATE_W = 7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [RATE_W-1:0] drawVal,
  input  logic [RATE_W-1:0] injRate,
  input  logic [1:0]        reqClass,
  input  logic              patternOk,
  input  logic              singleSenderEn,
  input  logic [NODE_W-1:0] senderId,
  input  logic [NODE_W-1:0] nodeId,
  input  logic              pktReady,
  output ctlStrobes_t       strobes,
  output logic              pktValid
);

  logic slotFree, rateOk, senderOk, classOk, fire;

  assign slotFree = !pktValid || pktReady;
  assign rateOk   = drawVal < injRate;
  assign senderOk = !singleSenderEn || (senderId == nodeId);
  assign classOk  = reqClass != CLASS_BAD;
  assign fire     = slotFree && rateOk && senderOk && classOk && patternOk;

  assign strobes.draw = slotFree;
  assign strobes.load = fire;

  always_ff @(posedge clk) begin
    if (!rst_n)
      pktValid <= 1'b0;
    else if (slotFree)
      pktValid <= fire;
  end

endmodule

// File: rtl/traffic_injector.sv
module traffic_injector
  import traffic_injector_pkg::*;
#(
  parameter int          RADIX_BITS   = 2,
  parameter int          BLOCK_OFFSET = 6,
  parameter int          ADDR_W       = 32,
  parameter int          PRECISION    = 2,
  parameter logic [15:0] SEED         = 16'hACE1,
  localparam int NODE_W = 2 * RADIX_BITS,
  localparam int RATE_W = $clog2(10 ** PRECISION + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NODE_W-1:0] nodeId,
  input  logic [2:0]        pattern,
  input  logic [1:0]        reqClass,
  input  logic [RATE_W-1:0] injRate,
  input  logic              singleSenderEn,
  input  logic [NODE_W-1:0] senderId,
  input  logic              singleDestEn,
  input  logic [NODE_W-1:0] destCfg,
  output logic              pktValid,
  input  logic              pktReady,
  output logic [NODE_W-1:0] pktDest,
  output logic [ADDR_W-1:0] pktAddr,
  output logic [1:0]        pktClass
);

  ctlStrobes_t       strobes;
  logic [RATE_W-1:0] drawVal;
  logic              patternOk;

  traffic_injector_dp #(
    .RADIX_BITS(RADIX_BITS), .BLOCK_OFFSET(BLOCK_OFFSET),
    .ADDR_W(ADDR_W), .PRECISION(PRECISION), .SEED(SEED)
  ) uDp (
    .clk(clk), .rst_n(rst_n), .nodeId(nodeId),
    .pattern(pattern_e'(pattern)), .reqClass(reqClass),
    .singleDestEn(singleDestEn), .destCfg(destCfg), .strobes(strobes),
    .drawVal(drawVal), .patternOk(patternOk),
    .pktDest(pktDest), .pktAddr(pktAddr), .pktClass(pktClass)
  );

  traffic_injector_ctl #(.NODE_W(NODE_W), .RATE_W(RATE_W)) uCtl (
    .clk(clk), .rst_n(rst_n), .drawVal(drawVal), .injRate(injRate),
    .reqClass(reqClass), .patternOk(patternOk),
    .singleSenderEn(singleSenderEn), .senderId(senderId), .nodeId(nodeId),
    .pktReady(pktReady), .strobes(strobes), .pktValid(pktValid)
  );

endmodule

// File: rtl/traffic_injector_chk.sv
module traffic_injector_chk #(
  parameter int RADIX_BITS   = 2,
  parameter int BLOCK_OFFSET = 6,
  parameter int ADDR_W       = 32,
  parameter int PRECISION    = 2,
  localparam int NODE_W = 2 * RADIX_BITS,
  localparam int RATE_W = $clog2(10 ** PRECISION + 1)
) (
  input logic              clk,
  input logic              rst_n,
  input logic [NODE_W-1:0] nodeId,
  input logic [RATE_W-1:0] injRate,
  input logic              singleSenderEn,
  input logic [NODE_W-1:0] senderId,
  input logic              singleDestEn,
  input logic [NODE_W-1:0] destCfg,
  input logic              pktValid,
  input logic              pktReady,
  input logic [NODE_W-1:0] pktDest,
  input logic [ADDR_W-1:0] pktAddr,
  input logic [1:0]        pktClass
);

  logic slotFree;
  assign slotFree = !pktValid || pktReady;

  // R13
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pktValid && !pktReady) |=> (pktValid && $stable(pktDest) &&
                                 $stable(pktAddr) && $stable(pktClass)));

  // R10
  addr_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pktValid |-> (pktAddr[BLOCK_OFFSET-1:0] == '0 &&
                  (pktAddr >> BLOCK_OFFSET) == ADDR_W'(pktDest)));

  // R9
  class_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pktValid |-> (pktClass != 2'd3));

  // R2
  zero_rate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (slotFree && injRate == '0) |=> !pktValid);

  // R11
  single_sender_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (slotFree && singleSenderEn && senderId != nodeId) |=> !pktValid);

  // R12
  single_dest_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (slotFree && singleDestEn) |=> (!pktValid || pktDest == $past(destCfg)));

endmodule

bind traffic_injector traffic_injector_chk #(
  .RADIX_BITS(RADIX_BITS), .BLOCK_OFFSET(BLOCK_OFFSET),
  .ADDR_W(ADDR_W), .PRECISION(PRECISION)
) uChk (
  .clk(clk), .rst_n(rst_n), .nodeId(nodeId), .injRate(injRate),
  .singleSenderEn(singleSenderEn), .senderId(senderId),
  .singleDestEn(singleDestEn), .destCfg(destCfg),
  .pktValid(pktValid), .pktReady(pktReady), .pktDest(pktDest),
  .pktAddr(pktAddr), .pktClass(pktClass)
);

// File: tb/traffic_injector_test.sv
`timescale 1ns/1ps
module traffic_injector_test;

  localparam int RB = 3;
  localparam int NW = 2 * RB;
  localparam int RADIX = 1 << RB;
  localparam int NN = 1 << NW;
  localparam int OFS = 6;
  localparam int AW = 32;
  localparam int RW = $clog2(100 + 1);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [NW-1:0] nodeId = '0, senderId = '0, destCfg = '0;
  logic [2:0] pattern = 3'd1;
  logic [1:0] reqClass = 2'd0;
  logic [RW-1:0] injRate = RW'(100);
  logic singleSenderEn = 1'b0, singleDestEn = 1'b0, pktReady = 1'b1;
  logic pktValid;
  logic [NW-1:0] pktDest;
  logic [AW-1:0] pktAddr;
  logic [1:0] pktClass;

  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  traffic_injector #(.RADIX_BITS(RB), .BLOCK_OFFSET(OFS), .ADDR_W(AW),
                     .PRECISION(2)) uut (
    .clk(clk), .rst_n(rst_n), .nodeId(nodeId), .pattern(pattern),
    .reqClass(reqClass), .injRate(injRate), .singleSenderEn(singleSenderEn),
    .senderId(senderId), .singleDestEn(singleDestEn), .destCfg(destCfg),
    .pktValid(pktValid), .pktReady(pktReady), .pktDest(pktDest),
    .pktAddr(pktAddr), .pktClass(pktClass)
  );

  task automatic check(string tag, longint act, longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  function automatic int expDest(int id, int pat);
    int x = id % RADIX;
    int y = id / RADIX;
    int r = 0;
    case (pat)
      1: return (RADIX - 1 - y) * RADIX + (RADIX - 1 - x);
      2: begin
        for (int b = 0; b < NW; b++) if ((id >> b) & 1) r |= 1 << (NW - 1 - b);
        return r;
      end
      3: return (id < NN / 2) ? 2 * id : 2 * id - NN + 1;
      4: return x * RADIX + y;
      5: return y * RADIX + (x + 1) % RADIX;
      6: return y * RADIX + (x + RADIX / 2 - 1) % RADIX;
      default: return -1;
    endcase
  endfunction

  function automatic string patTag(int pat);
    case (pat)
      1: return "R3 complement";
      2: return "R4 reverse";
      3: return "R5 shuffle";
      4: return "R6 transpose";
      default: return "R7 neighbour/tornado";
    endcase
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int cnt;
    bit seen [NN];
    int seenCnt;

    // R1 reset state
    repeat (3) @(negedge clk);
    check("R1 valid in reset", pktValid, 0);
    check("R1 addr in reset", pktAddr, 0);
    check("R1 dest in reset", pktDest, 0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R2 full rate first offer", pktValid, 1);

    // R3..R7, R9, R10: exhaustive node x pattern sweep
    for (int n = 0; n < NN; n++) begin
      for (int p = 1; p <= 6; p++) begin
        nodeId = NW'(n);
        pattern = 3'(p);
        reqClass = 2'((n + p) % 3);
        @(negedge clk);
        check(patTag(p), pktDest, expDest(n, p));
        check("R10 address", pktAddr, longint'(expDest(n, p)) << OFS);
        check("R9 class", pktClass, (n + p) % 3);
        check("R2 valid", pktValid, 1);
      end
    end

    // R8 uniform coverage
    pattern = 3'd0;
    seenCnt = 0;
    for (int i = 0; i < 3000; i++) begin
      @(negedge clk);
      if (pktValid && !seen[pktDest]) begin
        seen[pktDest] = 1'b1;
        seenCnt++;
      end
    end
    check("R8 uniform coverage", seenCnt, NN);

    // R8 pattern 7 gives nothing
    pattern = 3'd7;
    @(negedge clk);
    check("R8 code 7 no packet", pktValid, 0);

    // R9 class 3 gives nothing
    pattern = 3'd1;
    reqClass = 2'd3;
    @(negedge clk);
    check("R9 class 3 no packet", pktValid, 0);
    reqClass = 2'd2;

    // R2 rate extremes and midpoint
    injRate = '0;
    cnt = 0;
    for (int i = 0; i < 200; i++) begin
      @(negedge clk);
      cnt += int'(pktValid);
    end
    check("R2 rate zero", cnt, 0);
    injRate = RW'(100);
    @(negedge clk);
    cnt = 0;
    for (int i = 0; i < 200; i++) begin
      @(negedge clk);
      cnt += int'(pktValid);
    end
    check("R2 rate full", cnt, 200);
    injRate = RW'(50);
    cnt = 0;
    for (int i = 0; i < 2000; i++) begin
      @(negedge clk);
      cnt += int'(pktValid);
    end
    check("R2 rate half in band", (cnt > 600 && cnt < 1400), 1);
    injRate = RW'(100);

    // R11 single sender
    singleSenderEn = 1'b1;
    nodeId = NW'(9);
    senderId = NW'(10);
    @(negedge clk);
    @(negedge clk);
    check("R11 other node silent", pktValid, 0);
    senderId = NW'(9);
    @(negedge clk);
    check("R11 chosen node sends", pktValid, 1);
    singleSenderEn = 1'b0;

    // R12 single destination
    singleDestEn = 1'b1;
    destCfg = NW'(42);
    for (int p = 0; p <= 6; p++) begin
      pattern = 3'(p);
      @(negedge clk);
      check("R12 forced dest", pktDest, 42);
    end
    singleDestEn = 1'b0;

    // R13 stall hold
    nodeId = NW'(5);
    pattern = 3'd1;
    @(negedge clk);
    check("R13 pre-stall dest", pktDest, expDest(5, 1));
    pktReady = 1'b0;
    nodeId = NW'(9);
    pattern = 3'd4;
    reqClass = 2'd1;
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      check("R13 held valid", pktValid, 1);
      check("R13 held dest", pktDest, expDest(5, 1));
      check("R13 held class", pktClass, 2);
    end
    pktReady = 1'b1;
    @(negedge clk);
    check("R13 after release", pktDest, expDest(9, 4));
    check("R13 class after release", pktClass, 1);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule